// File: doc/BRIEF.md
# Wallace Tree Multiplier (8x8 Unsigned)

A purely combinational unsigned multiplier. Two N-bit operands (N = 8 by default) produce a 2N-bit product with no clock, no reset and no state. Each bit of operand A gates a whole copy of operand B to form one shifted partial-product row. Carry-save stages built from half and full adders then compress these rows, following a fixed grouping schedule over four reduction layers, until only two rows are left. A ripple-carry adder adds those two rows to give the product.

The schedule runs as follows. In layer 1, rows 0-2 are compressed together and rows 3-5 are compressed together, while rows 6-7 pass through. In layer 2, the first triple's sum and carry rows join the second triple's sum row, and rows 6-7 join the second triple's carry row. In layer 3, three of the four resulting rows are compressed and the fourth passes through. Layer 4 compresses the last three rows into two. The cell used in each column is chosen when the design is elaborated, from how many bits that column actually holds: three bits take a full adder, two take a half adder, and a single bit is wired straight through. The block has no states, so there are no state names or transitions.

Top module: `wtree_mult`

## Requirements
- R1: For every pair of operands, `prod` equals the unsigned product `opa * opb`, reported on 2N = 16 bits.
- R2: When either operand is zero, `prod` is zero. This includes the all-zero input that the block sees when operation starts.
- R3: When one operand is 1, `prod` equals the other operand, zero-extended.
- R4: The largest operands (255 x 255) give 65025 (0xFE01). The 16-bit result never wraps.
- R5: A single set bit i in `opa` and a single set bit j in `opb` give a product with exactly one set bit, at position i+j.
- R6: An all-ones operand makes the carries ripple across the full width: 255 x b gives 256*b - b for every b.
- R7: The output is combinational. A change on either operand shows up on `prod` within the same time step, with no clock edge.
- R8: Swapping the operands does not change the product.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| opa | input | N (8) | Multiplicand; bit i selects partial-product row i |
| opb | input | N (8) | Multiplier; the bits of each partial-product row |
| prod | output | 2N (16) | Unsigned product |

## Verification
The hardest case to reach from the ports is a final addition in which the two rows left after layer 4 send a carry through almost every column of the ripple adder. Only particular operand pairs, dense in ones, produce that. Rather than searching for those pairs, the stimulus sweeps every one of the 65536 operand pairs, so every possible carry pattern in every layer is applied. Before the sweep, directed vectors cover zero, identity, single-bit and all-ones operands, and a separate step checks that the output follows the inputs with no clock involved.

// File: rtl/wt_pkg.sv
package wt_pkg;

    // Cell placed in one column of a carry-save stage
    typedef enum logic [1:0] {
        CELL_NONE,
        CELL_PASS,
        CELL_HALF,
        CELL_FULL
    } cell_kind_e;

    function automatic cell_kind_e kind_of(input int bits_in_column);
        case (bits_in_column)
            0:       return CELL_NONE;
            1:       return CELL_PASS;
            2:       return CELL_HALF;
            default: return CELL_FULL;
        endcase
    endfunction

endpackage

// File: rtl/wt_half_add.sv
module wt_half_add (
    input  logic a,
    input  logic b,
    output logic s,
    output logic co
);
    assign s  = a ^ b;
    assign co = a & b;
endmodule

// File: rtl/wt_full_add.sv
module wt_full_add (
    input  logic a,
    input  logic b,
    input  logic ci,
    output logic s,
    output logic co
);
    logic s_mid, c_lo, c_hi;

    wt_half_add u_ha_lo (.a(a),     .b(b),  .s(s_mid), .co(c_lo));
    wt_half_add u_ha_hi (.a(s_mid), .b(ci), .s(s),     .co(c_hi));

    assign co = c_lo | c_hi;
endmodule

// File: rtl/wtree_pp_row.sv
// One partial-product row: a single multiplicand bit gating every multiplier bit
module wtree_pp_row #(
    parameter int N = 8
) (
    input  logic         sel,
    input  logic [N-1:0] mb,
    output logic [N-1:0] row
);
    for (genvar j = 0; j < N; j++) begin : g_and
        assign row[j] = sel & mb[j];
    end
endmodule

// File: rtl/wtree_csa.sv
// Three rows in, two rows out. The cell in each column is picked from the
// occupancy masks, so columns that hold fewer than three bits use fewer gates.
module wtree_csa
    import wt_pkg::*;
#(
    parameter int           W     = 16,
    parameter logic [W-1:0] OCC_X = '1,
    parameter logic [W-1:0] OCC_Y = '1,
    parameter logic [W-1:0] OCC_Z = '1
) (
    input  logic [W-1:0] x,
    input  logic [W-1:0] y,
    input  logic [W-1:0] z,
    output logic [W-1:0] s,
    output logic [W-1:0] c
);
    assign c[0] = 1'b0;

    for (genvar k = 0; k < W; k++) begin : g_col
        localparam int         CNT  = int'(OCC_X[k]) + int'(OCC_Y[k]) + int'(OCC_Z[k]);
        localparam cell_kind_e KIND = kind_of(CNT);

        if (k == W - 1) begin : g_top
            // The product fits in W bits, so no carry leaves the top column
            assign s[k] = x[k] ^ y[k] ^ z[k];
        end else if (KIND == CELL_FULL) begin : g_fa
            wt_full_add u_fa (.a(x[k]), .b(y[k]), .ci(z[k]), .s(s[k]), .co(c[k+1]));
        end else if (KIND == CELL_HALF) begin : g_ha
            // The empty input is constant zero, so it is ORed into one operand
            if (!OCC_X[k]) begin : g_yz
                wt_half_add u_ha (.a(y[k]), .b(z[k] | x[k]), .s(s[k]), .co(c[k+1]));
            end else if (!OCC_Y[k]) begin : g_xz
                wt_half_add u_ha (.a(x[k]), .b(z[k] | y[k]), .s(s[k]), .co(c[k+1]));
            end else begin : g_xy
                wt_half_add u_ha (.a(x[k]), .b(y[k] | z[k]), .s(s[k]), .co(c[k+1]));
            end
        end else begin : g_wire
            // A lone bit, or nothing: the unused inputs are zero
            assign s[k]   = x[k] | y[k] | z[k];
            assign c[k+1] = 1'b0;
        end
    end
endmodule

// File: rtl/wtree_ripple.sv
// Final two-row adder: a half adder at the LSB, then a chain of full adders
module wtree_ripple #(
    parameter int W = 16
) (
    input  logic [W-1:0] x,
    input  logic [W-1:0] y,
    output logic [W-1:0] sum
);
    logic [W-1:1] cy;

    wt_half_add u_lsb (.a(x[0]), .b(y[0]), .s(sum[0]), .co(cy[1]));

    for (genvar k = 1; k < W - 1; k++) begin : g_bit
        wt_full_add u_fa (.a(x[k]), .b(y[k]), .ci(cy[k]), .s(sum[k]), .co(cy[k+1]));
    end

    assign sum[W-1] = x[W-1] ^ y[W-1] ^ cy[W-1];
endmodule

// File: rtl/wtree_mult.sv
// Unsigned N x N Wallace tree multiplier with a fixed eight-row grouping schedule
module wtree_mult #(
    parameter int N = 8
) (
    input  logic [N-1:0]   opa,
    input  logic [N-1:0]   opb,
    output logic [2*N-1:0] prod
);
    localparam int W = 2 * N;

    // Elaboration-time bit occupancy of each row
    function automatic logic [W-1:0] occ_row(input int i);
        return W'((1 << N) - 1) << i;
    endfunction

    function automatic logic [W-1:0] occ_carry(input logic [W-1:0] ox,
                                                input logic [W-1:0] oy,
                                                input logic [W-1:0] oz);
        logic [W-1:0] r;
        r = '0;
        for (int k = 0; k < W - 1; k++) begin
            r[k+1] = (int'(ox[k]) + int'(oy[k]) + int'(oz[k])) >= 2;
        end
        return r;
    endfunction

    // Occupancy through the schedule
    localparam logic [W-1:0] OCC_S1 = occ_row(0) | occ_row(1) | occ_row(2);
    localparam logic [W-1:0] OCC_C1 = occ_carry(occ_row(0), occ_row(1), occ_row(2));
    localparam logic [W-1:0] OCC_S2 = occ_row(3) | occ_row(4) | occ_row(5);
    localparam logic [W-1:0] OCC_C2 = occ_carry(occ_row(3), occ_row(4), occ_row(5));
    localparam logic [W-1:0] OCC_S4 = OCC_S1 | OCC_C1 | OCC_S2;
    localparam logic [W-1:0] OCC_C4 = occ_carry(OCC_S1, OCC_C1, OCC_S2);
    localparam logic [W-1:0] OCC_S5 = occ_row(6) | occ_row(7) | OCC_C2;
    localparam logic [W-1:0] OCC_C5 = occ_carry(occ_row(6), occ_row(7), OCC_C2);
    localparam logic [W-1:0] OCC_S6 = OCC_S4 | OCC_C4 | OCC_S5;
    localparam logic [W-1:0] OCC_C6 = occ_carry(OCC_S4, OCC_C4, OCC_S5);

    // Partial-product rows, each shifted to its weight
    logic [W-1:0] pp [N];

    for (genvar i = 0; i < N; i++) begin : g_row
        logic [N-1:0] row_bits;
        wtree_pp_row #(.N(N)) u_row (.sel(opa[i]), .mb(opb), .row(row_bits));
        assign pp[i] = W'(row_bits) << i;
    end

    // Layer 1: two triples compressed, rows 6 and 7 wait
    logic [W-1:0] g1_s, g1_c, g2_s, g2_c;

    wtree_csa #(.W(W), .OCC_X(occ_row(0)), .OCC_Y(occ_row(1)), .OCC_Z(occ_row(2)))
        u_l1_g1 (.x(pp[0]), .y(pp[1]), .z(pp[2]), .s(g1_s), .c(g1_c));
    wtree_csa #(.W(W), .OCC_X(occ_row(3)), .OCC_Y(occ_row(4)), .OCC_Z(occ_row(5)))
        u_l1_g2 (.x(pp[3]), .y(pp[4]), .z(pp[5]), .s(g2_s), .c(g2_c));

    // Layer 2: second-triple sums join the first triple; its carries join rows 6-7
    logic [W-1:0] g4_s, g4_c, g5_s, g5_c;

    wtree_csa #(.W(W), .OCC_X(OCC_S1), .OCC_Y(OCC_C1), .OCC_Z(OCC_S2))
        u_l2_g4 (.x(g1_s), .y(g1_c), .z(g2_s), .s(g4_s), .c(g4_c));
    wtree_csa #(.W(W), .OCC_X(occ_row(6)), .OCC_Y(occ_row(7)), .OCC_Z(OCC_C2))
        u_l2_g5 (.x(pp[6]), .y(pp[7]), .z(g2_c), .s(g5_s), .c(g5_c));

    // Layer 3: three rows compressed, the last carry row passes on
    logic [W-1:0] g6_s, g6_c, g7_pass;

    wtree_csa #(.W(W), .OCC_X(OCC_S4), .OCC_Y(OCC_C4), .OCC_Z(OCC_S5))
        u_l3_g6 (.x(g4_s), .y(g4_c), .z(g5_s), .s(g6_s), .c(g6_c));
    assign g7_pass = g5_c;

    // Layer 4: last compression, at most two bits per column remain
    logic [W-1:0] l4_s, l4_c;

    wtree_csa #(.W(W), .OCC_X(OCC_S6), .OCC_Y(OCC_C6), .OCC_Z(OCC_C5))
        u_l4 (.x(g6_s), .y(g6_c), .z(g7_pass), .s(l4_s), .c(l4_c));

    // Final carry-propagate addition
    wtree_ripple #(.W(W)) u_cpa (.x(l4_s), .y(l4_c), .sum(prod));

endmodule

// File: rtl/wtree_mult_chk.sv
module wtree_mult_chk #(
    parameter int N = 8
) (
    input logic [N-1:0]   opa,
    input logic [N-1:0]   opb,
    input logic [2*N-1:0] prod,
    input logic [2*N-1:0] g1_s,
    input logic [2*N-1:0] g1_c,
    input logic [2*N-1:0] g2_s,
    input logic [2*N-1:0] g2_c,
    input logic [2*N-1:0] g4_s,
    input logic [2*N-1:0] g4_c,
    input logic [2*N-1:0] g5_s,
    input logic [2*N-1:0] g5_c,
    input logic [2*N-1:0] l4_s,
    input logic [2*N-1:0] l4_c
);
    localparam int W = 2 * N;

    logic [W+3:0] ref_full, l1_total, l2_total, fin_total, hi_rows;

    always_comb begin
        ref_full  = (W+4)'(opa) * (W+4)'(opb);
        hi_rows   = (((W+4)'(opb) & {(W+4){opa[6]}}) << 6)
                  + (((W+4)'(opb) & {(W+4){opa[7]}}) << 7);
        l1_total  = (W+4)'(g1_s) + (W+4)'(g1_c) + (W+4)'(g2_s) + (W+4)'(g2_c) + hi_rows;
        l2_total  = (W+4)'(g4_s) + (W+4)'(g4_c) + (W+4)'(g5_s) + (W+4)'(g5_c);
        fin_total = (W+4)'(l4_s) + (W+4)'(l4_c);

        if (!$isunknown({opa, opb})) begin
            p_product_r1: assert ((W+4)'(prod) == ref_full)
                else $error("product %0d differs from %0d x %0d", prod, opa, opb);
            p_layer1_value_r1: assert (l1_total == ref_full)
                else $error("layer 1 rows do not sum to the product");
            p_layer2_value_r1: assert (l2_total == ref_full)
                else $error("layer 2 rows do not sum to the product");
            p_final_rows_r1: assert (W'(fin_total) == prod)
                else $error("ripple adder result differs from its two rows");
            p_zero_operand_r2: assert (!(opa == '0 || opb == '0) || prod == '0)
                else $error("zero operand gave a non-zero product");
            p_identity_r3: assert (opb != N'(1) || prod == W'(opa))
                else $error("multiplying by one changed the operand");
        end
    end
endmodule

bind wtree_mult wtree_mult_chk #(.N(N)) u_chk (
    .opa(opa), .opb(opb), .prod(prod),
    .g1_s(g1_s), .g1_c(g1_c), .g2_s(g2_s), .g2_c(g2_c),
    .g4_s(g4_s), .g4_c(g4_c), .g5_s(g5_s), .g5_c(g5_c),
    .l4_s(l4_s), .l4_c(l4_c)
);

// File: tb/wtree_mult_bench.sv
`timescale 1ns/1ps
module wtree_mult_bench;

    localparam int N = 8;
    localparam int W = 2 * N;

    typedef struct {
        string        tag;
        logic [N-1:0] a;
        logic [N-1:0] b;
        logic [W-1:0] exp;
    } item_t;

    logic         clk = 1'b0;
    logic         rst = 1'b1;
    logic [N-1:0] opa = '0;
    logic [N-1:0] opb = '0;
    logic [W-1:0] prod;

    int    n_vec  = 0;
    int    n_bad  = 0;
    int    cycles = 0;
    bit    done   = 1'b0;
    item_t sb_q[$];

    always #2 clk = ~clk;   // 4 ns period

    wtree_mult #(.N(N)) u_wtree_mult (.opa(opa), .opb(opb), .prod(prod));

    function automatic logic [W-1:0] mul_ref(input logic [N-1:0] a, input logic [N-1:0] b);
        return W'({{N{1'b0}}, a} * {{N{1'b0}}, b});
    endfunction

    // Driver: apply on the falling edge and queue the expectation
    task automatic drive(input string tag, input logic [N-1:0] a,
                         input logic [N-1:0] b, input logic [W-1:0] exp);
        item_t it;
        @(negedge clk);
        opa = a;
        opb = b;
        it.tag = tag; it.a = a; it.b = b; it.exp = exp;
        sb_q.push_back(it);
    endtask

    task automatic report(input string tag, input logic [W-1:0] act, input logic [W-1:0] exp,
                          input logic [N-1:0] a, input logic [N-1:0] b);
        n_vec++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: a=%0d b=%0d actual=%0d expected=%0d", tag, a, b, act, exp);
        end
    endtask

    // Monitor: pop and compare 1 ns after each rising edge
    initial begin
        forever begin
            @(posedge clk);
            #1;
            if (sb_q.size() > 0) begin
                item_t it;
                it = sb_q.pop_front();
                report(it.tag, prod, it.exp, it.a, it.b);
            end
        end
    end

    // Watchdog
    always @(posedge clk) begin
        cycles <= cycles + 1;
        if (cycles > 150000 && !done) begin
            n_vec++;
            n_bad++;
            $display("FAIL watchdog: actual=%0d cycles expected=<150000", cycles);
            $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
            $finish;
        end
    end

    initial begin
        repeat (3) @(posedge clk);
        #1;
        // R2: all-zero inputs at start of operation
        report("R2 start", prod, '0, opa, opb);
        rst = 1'b0;

        // R2: zero on either side
        drive("R2", 8'd0,   8'd173, 16'd0);
        drive("R2", 8'd255, 8'd0,   16'd0);
        // R3: identity
        drive("R3", 8'd1,   8'd200, 16'd200);
        drive("R3", 8'd97,  8'd1,   16'd97);
        // R4: largest operands
        drive("R4", 8'd255, 8'd255, 16'hFE01);
        // R5: one bit each, lands at i+j
        for (int i = 0; i < N; i++) begin
            for (int j = 0; j < N; j++) begin
                drive("R5", N'(1 << i), N'(1 << j), W'(1 << (i + j)));
            end
        end
        // R6: all-ones operand, 256*b - b
        for (int b = 0; b < 256; b++) begin
            drive("R6", 8'd255, N'(b), W'(256 * b - b));
        end
        // R8: swapped operands
        drive("R8", 8'd13,  8'd211, 16'd2743);
        drive("R8", 8'd211, 8'd13,  16'd2743);
        drive("R8", 8'd170, 8'd85,  16'd14450);
        drive("R8", 8'd85,  8'd170, 16'd14450);

        // R1: exhaustive sweep
        for (int a = 0; a < 256; a++) begin
            for (int b = 0; b < 256; b++) begin
                drive("R1", N'(a), N'(b), mul_ref(N'(a), N'(b)));
            end
        end

        while (sb_q.size() > 0) @(posedge clk);
        #2;

        // R7: output follows inputs with no clock edge in between
        @(negedge clk);
        opa = 8'd77;
        opb = 8'd139;
        #0.5;
        report("R7", prod, 16'd10703, opa, opb);
        opb = 8'd3;
        #0.5;
        report("R7", prod, 16'd231, opa, opb);

        done = 1'b1;
        $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
        $finish;
    end

endmodule